// File: doc/BRIEF.md
# Bridge One-Direction Ordering Queue

This block holds the traffic that crosses a bus-to-bus bridge in one direction and decides what the outbound master may start next. Posted memory writes are acknowledged at once and go into a FIFO. Each accepted write keeps its own FIFO entry. Non-posted reads are handled as delayed transactions. The first attempt of a read captures its address and command into a free slot and is answered with retry. The read then runs on the far side. A later repeat of the same request collects the returned data.

The initiator-side interface is one cycle per attempt. `t_ack` high means the attempt completed. `t_ack` low while `t_req` is high means retry. A transaction takes its place in the order only when it completes. At that point it receives the next order number on `t_tag`. The outbound side presents one transaction at a time. `m_done` ends it as completed. If `m_done` stays low, the far side retried it and the transaction stays queued. A second instance of the block serves the opposite direction and shares no state with this one.

Top module: `bridge_order_q`

## Requirements
- R1: Reset empties the FIFO, clears every slot, sets the order tag to zero and drops `m_valid`.
- R2: Each accepted write (`t_write`=1) leaves as exactly one outbound write (`m_write`=1). The outbound writes keep acceptance order, and each carries the address, data and byte enables it was accepted with. Writes are never combined, never byte-merged at the same dword address, and never collapsed at the same address.
- R3: A write that arrives while `fifo_cnt` equals DEPTH gets retry (`t_ack`=0). The FIFO is left unchanged.
- R4: A write is acknowledged whenever the FIFO has space, whatever the state of the delayed slots.
- R5: A read (`t_write`=0) that matches no slot takes the lowest free slot and gets retry. When no slot is free, the read gets retry and nothing is allocated.
- R6: A read that matches a valid slot on both address and command gets retry until that slot holds its completion. After that, the read gets `t_ack`=1 and `t_rdata` carries the slot's data, and the slot is freed.
- R7: A slot's read is not presented outbound while any write accepted before the read's allocation is still queued. An eligible read is presented ahead of writes accepted after it.
- R8: When several slots are eligible, the slot chosen is the first one at or after a round-robin pointer. The pointer moves past each slot whose outbound read completes.
- R9: `t_tag` is the order number given to the transaction being acknowledged. It rises by one after each completed attempt and does not move on a retry.
- R10: An outbound attempt without `m_done` changes no state. Completed reads may be collected by their requesters in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_req | input | 1 | Initiator attempt present this cycle |
| t_write | input | 1 | 1 = posted memory write, 0 = delayed read |
| t_cmd | input | 4 | Read command code |
| t_addr | input | AW | Attempt address |
| t_data | input | DW | Write data |
| t_be | input | DW/8 | Write byte enables |
| t_ack | output | 1 | Attempt completed (low with t_req = retry) |
| t_rdata | output | DW | Read data when a read completes |
| t_tag | output | TAGW | Order number of the completing attempt |
| m_valid | output | 1 | Outbound transaction presented |
| m_write | output | 1 | 1 = outbound write, 0 = outbound read |
| m_cmd | output | 4 | Outbound command |
| m_addr | output | AW | Outbound address |
| m_data | output | DW | Outbound write data |
| m_be | output | DW/8 | Outbound byte enables |
| m_slot | output | SW | Slot of the outbound read |
| m_done | input | 1 | Outbound transaction completed (otherwise retried) |
| m_rdata | input | DW | Read data returned with m_done |
| fifo_cnt | output | CW | Posted FIFO occupancy |
| slot_vld | output | NSLOT | Slot-in-use flags |
| slot_cpl | output | NSLOT | Slot-completion-held flags |

## Verification
The bench builds the block with its defaults: a four-entry FIFO and two slots. With these values a handful of writes is enough to reach the full condition. Both slots fill from a few reads, so the no-free-slot retry and a round-robin choice between two eligible reads are both reachable. The FIFO is filled with writes that share a dword or a full address, so that any merging or collapsing would change the outbound count or the values. A read is placed behind queued writes and ahead of a later one to test both sides of the drain rule.

// File: rtl/bridge_order_q.sv
module bridge_order_q #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int NSLOT = 2,
  parameter int TAGW  = 8,
  parameter logic [3:0] WCMD = 4'h7,
  localparam int BEW = DW / 8,
  localparam int PW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int SW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            t_req,
  input  logic            t_write,
  input  logic [3:0]      t_cmd,
  input  logic [AW-1:0]   t_addr,
  input  logic [DW-1:0]   t_data,
  input  logic [BEW-1:0]  t_be,
  output logic            t_ack,
  output logic [DW-1:0]   t_rdata,
  output logic [TAGW-1:0] t_tag,
  output logic            m_valid,
  output logic            m_write,
  output logic [3:0]      m_cmd,
  output logic [AW-1:0]   m_addr,
  output logic [DW-1:0]   m_data,
  output logic [BEW-1:0]  m_be,
  output logic [SW-1:0]   m_slot,
  input  logic            m_done,
  input  logic [DW-1:0]   m_rdata,
  output logic [CW-1:0]   fifo_cnt,
  output logic [NSLOT-1:0] slot_vld,
  output logic [NSLOT-1:0] slot_cpl
);

  logic [AW-1:0]  f_addr [DEPTH];
  logic [DW-1:0]  f_data [DEPTH];
  logic [BEW-1:0] f_be   [DEPTH];
  logic [PW-1:0]  wp, rp;

  logic [NSLOT-1:0] s_vld, s_cpl, hit, elig;
  logic [AW-1:0]    s_addr [NSLOT];
  logic [3:0]       s_cmd  [NSLOT];
  logic [DW-1:0]    s_data [NSLOT];
  logic [CW-1:0]    s_wc   [NSLOT];
  logic [SW-1:0]    rr, pick, hit_idx, free_idx;
  logic             rd_go, free_ok;

  wire full   = (fifo_cnt == CW'(DEPTH));
  wire empty  = (fifo_cnt == '0);
  wire rd     = t_req & ~t_write;
  wire push   = t_req & t_write & ~full;
  wire pop    = m_valid & m_write & m_done;
  wire rd_fin = m_valid & ~m_write & m_done;
  wire alloc  = rd & ~(|hit) & free_ok;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    free_ok  = 1'b0;
    pick     = '0;
    rd_go    = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      hit[i]  = s_vld[i] && s_addr[i] == t_addr && s_cmd[i] == t_cmd;
      elig[i] = s_vld[i] && !s_cpl[i] && s_wc[i] == '0;
      if (hit[i]) hit_idx = SW'(i);
      if (!s_vld[i]) begin
        free_idx = SW'(i);
        free_ok  = 1'b1;
      end
    end
    for (int k = NSLOT - 1; k >= 0; k--) begin
      int j;
      j = (int'(rr) + k) % NSLOT;
      if (elig[j]) begin
        pick  = SW'(j);
        rd_go = 1'b1;
      end
    end
  end

  assign t_ack   = t_req & (t_write ? ~full : |(hit & s_cpl));
  assign t_rdata = s_data[hit_idx];
  assign m_valid = rd_go | ~empty;
  assign m_write = ~rd_go;
  assign m_cmd   = rd_go ? s_cmd[pick]  : WCMD;
  assign m_addr  = rd_go ? s_addr[pick] : f_addr[rp];
  assign m_data  = rd_go ? '0 : f_data[rp];
  assign m_be    = rd_go ? '1 : f_be[rp];
  assign m_slot  = pick;
  assign slot_vld = s_vld;
  assign slot_cpl = s_cpl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      fifo_cnt <= '0;
      t_tag <= '0;
      rr <= '0;
      s_vld <= '0;
      s_cpl <= '0;
    end else begin
      if (push) begin
        f_addr[wp] <= t_addr;
        f_data[wp] <= t_data;
        f_be[wp]   <= t_be;
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      fifo_cnt <= fifo_cnt + CW'(push) - CW'(pop);
      if (t_ack) t_tag <= t_tag + 1'b1;
      if (rd_fin) rr <= (int'(pick) == NSLOT - 1) ? '0 : pick + 1'b1;
      for (int i = 0; i < NSLOT; i++) begin
        if (rd_fin && pick == SW'(i)) begin
          s_cpl[i]  <= 1'b1;
          s_data[i] <= m_rdata;
        end
        if (t_ack && rd && hit[i]) begin
          s_vld[i] <= 1'b0;
          s_cpl[i] <= 1'b0;
        end
        if (alloc && free_idx == SW'(i)) begin
          s_vld[i]  <= 1'b1;
          s_cpl[i]  <= 1'b0;
          s_addr[i] <= t_addr;
          s_cmd[i]  <= t_cmd;
          s_wc[i]   <= fifo_cnt - CW'(pop);
        end else if (pop && s_wc[i] != '0) begin
          s_wc[i] <= s_wc[i] - 1'b1;
        end
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));
  p_full_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    t_req && t_write && fifo_cnt == CW'(DEPTH) |-> !t_ack);
  p_cnt_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (t_ack && t_write && !pop) |=> fifo_cnt == $past(fifo_cnt) + 1'b1);
  p_rd_behind_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_write |-> s_wc[m_slot] == '0);
  p_rd_ack_cpl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    t_ack && !t_write |-> |(slot_vld & slot_cpl));
  p_tag_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    t_ack |=> t_tag == $past(t_tag) + 1'b1);
  p_tag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    t_req && !t_ack |=> $stable(t_tag));

endmodule

// File: tb/bridge_order_q_tb.sv
module bridge_order_q_tb_top;
  logic clk = 0, rst_n = 0;
  logic t_req = 0, t_write = 0;
  logic [3:0] t_cmd = 0;
  logic [31:0] t_addr = 0, t_data = 0, m_rdata = 0;
  logic [3:0] t_be = 0;
  logic t_ack, m_valid, m_write, m_done = 0;
  logic [31:0] t_rdata, m_addr, m_data;
  logic [7:0] t_tag;
  logic [3:0] m_cmd, m_be;
  logic [0:0] m_slot;
  logic [2:0] fifo_cnt;
  logic [1:0] slot_vld, slot_cpl;
  int checks = 0, fails = 0;
  logic ack_s;
  logic [31:0] rd_s;
  logic [7:0] tag_s;

  always #2.5 clk = ~clk;

  bridge_order_q dut_i (
    .clk(clk), .rst_n(rst_n), .t_req(t_req), .t_write(t_write), .t_cmd(t_cmd),
    .t_addr(t_addr), .t_data(t_data), .t_be(t_be), .t_ack(t_ack), .t_rdata(t_rdata),
    .t_tag(t_tag), .m_valid(m_valid), .m_write(m_write), .m_cmd(m_cmd),
    .m_addr(m_addr), .m_data(m_data), .m_be(m_be), .m_slot(m_slot),
    .m_done(m_done), .m_rdata(m_rdata), .fifo_cnt(fifo_cnt),
    .slot_vld(slot_vld), .slot_cpl(slot_cpl));

  localparam logic [67:0] WVEC [4] = '{
    {32'h0000_1000, 32'hAAAA_0001, 4'b0011},
    {32'h0000_1000, 32'hBBBB_0002, 4'b1100},
    {32'h0000_2000, 32'hCCCC_0003, 4'b1111},
    {32'h0000_2000, 32'hDDDD_0004, 4'b1111}};

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic txn(input logic w, input logic [3:0] c, input logic [31:0] a,
                     input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    t_req = 1; t_write = w; t_cmd = c; t_addr = a; t_data = d; t_be = be;
    #1;
    ack_s = t_ack; rd_s = t_rdata; tag_s = t_tag;
    @(posedge clk); #0.5;
    t_req = 0;
  endtask

  task automatic mfin(input logic [31:0] rd);
    @(negedge clk);
    m_done = 1; m_rdata = rd;
    @(posedge clk); #0.5;
    m_done = 0;
  endtask

  task automatic peek();
    @(negedge clk); #1;
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    peek();
    chk("R1 fifo_cnt", fifo_cnt, 0);
    chk("R1 slot_vld", slot_vld, 0);
    chk("R1 m_valid", m_valid, 0);
    chk("R1 t_tag", t_tag, 0);

    for (int i = 0; i < 4; i++) begin
      txn(1, 0, WVEC[i][67:36], WVEC[i][35:4], WVEC[i][3:0]);
      chk("R2 write ack", ack_s, 1);
      chk("R9 tag", tag_s, i);
    end
    peek();
    chk("R2 fifo_cnt", fifo_cnt, 4);

    txn(1, 0, 32'h3000, 32'hEEEE, 4'hF);
    chk("R3 full retry", ack_s, 0);
    chk("R9 tag on retry", tag_s, 4);
    peek();
    chk("R3 fifo unchanged", fifo_cnt, 4);

    txn(0, 4'h6, 32'h8000, 0, 0);
    chk("R5 new read retry", ack_s, 0);
    peek();
    chk("R5 slot alloc", slot_vld, 2'b01);
    txn(0, 4'h6, 32'h8000, 0, 0);
    chk("R6 repeat before cpl retry", ack_s, 0);

    for (int i = 0; i < 4; i++) begin
      peek();
      chk("R7 write ahead of read", {m_valid, m_write}, 2'b11);
      chk("R2 addr", m_addr, WVEC[i][67:36]);
      chk("R2 data", m_data, WVEC[i][35:4]);
      chk("R2 be", m_be, WVEC[i][3:0]);
      mfin(0);
    end
    peek();
    chk("R2 drained", fifo_cnt, 0);

    txn(1, 0, 32'h4000, 32'h4444, 4'hF);
    chk("R4 write while slot busy", ack_s, 1);
    chk("R9 tag", tag_s, 4);
    peek();
    chk("R7 read passes later write", {m_valid, m_write}, 2'b10);
    chk("R7 read addr", m_addr, 32'h8000);
    chk("R7 read cmd", m_cmd, 4'h6);
    mfin(32'h1234_5678);
    peek();
    chk("R6 slot cpl", slot_cpl, 2'b01);

    txn(0, 4'h7, 32'h8000, 0, 0);
    chk("R6 cmd mismatch retry", ack_s, 0);
    peek();
    chk("R5 second slot", slot_vld, 2'b11);
    txn(0, 4'h6, 32'h8000, 0, 0);
    chk("R6 collect ack", ack_s, 1);
    chk("R6 collect data", rd_s, 32'h1234_5678);
    chk("R9 tag", tag_s, 5);
    peek();
    chk("R6 slot freed", slot_vld, 2'b10);
    chk("R7 older write first", {m_write, m_addr}, {1'b1, 32'h4000});
    mfin(0);
    peek();
    chk("R7 read after", {m_write, m_addr, m_cmd}, {1'b0, 32'h8000, 4'h7});
    mfin(32'h55);
    txn(0, 4'h7, 32'h8000, 0, 0);
    chk("R6 collect slot1", rd_s, 32'h55);

    txn(0, 4'h6, 32'h9000, 0, 0);
    txn(0, 4'h6, 32'hA000, 0, 0);
    peek();
    chk("R8 first pick", m_addr, 32'h9000);
    peek();
    chk("R10 outbound retry holds", {m_addr, slot_cpl}, {32'h9000, 2'b00});
    mfin(32'hA1);
    txn(0, 4'h6, 32'h9000, 0, 0);
    chk("R6 collect A", rd_s, 32'hA1);
    txn(0, 4'h6, 32'hB000, 0, 0);
    peek();
    chk("R8 round robin pick", m_addr, 32'hA000);
    mfin(32'hB2);
    peek();
    chk("R8 next pick", m_addr, 32'hB000);
    mfin(32'hC3);
    txn(0, 4'h6, 32'hB000, 0, 0);
    chk("R10 collect C first", {ack_s, rd_s}, {1'b1, 32'hC3});
    txn(0, 4'h6, 32'hA000, 0, 0);
    chk("R10 collect B later", {ack_s, rd_s}, {1'b1, 32'hB2});
    chk("R9 tag", tag_s, 9);

    txn(0, 4'h6, 32'hD000, 0, 0);
    txn(0, 4'h6, 32'hE000, 0, 0);
    txn(0, 4'h6, 32'hF000, 0, 0);
    chk("R5 no free slot retry", ack_s, 0);
    peek();
    chk("R5 no extra alloc", {slot_vld, slot_cpl}, 4'b1100);
    txn(0, 4'h6, 32'hF000, 0, 0);
    chk("R5 unallocated stays retry", ack_s, 0);
    txn(1, 0, 32'h5000, 32'h5555, 4'hF);
    chk("R4 write with slots full", ack_s, 1);

    @(negedge clk); rst_n = 0;
    @(posedge clk); #0.5 rst_n = 1;
    peek();
    chk("R1 reset fifo", fifo_cnt, 0);
    chk("R1 reset slots", {slot_vld, slot_cpl}, 0);
    chk("R1 reset m_valid", m_valid, 0);
    chk("R1 reset tag", t_tag, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule